// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps the coherence state of one cache line in a write-back, invalidation-based snooping cache. It holds the four stable states (Modified, Exclusive, Shared, Invalid) and four waiting states that hold a pending bus request until the bus is granted. The processor side gives it loads, stores and evictions. The bus side shows it the transactions of other agents, and it answers each one with a shared, dirty and flush indication.

A request that hits completes without the bus. A request that misses, that needs ownership, or that evicts dirty data raises `bus_req` with a command. The command is issued when the grant arrives. Snoops are served in every cycle, including while a request is pending. A snoop that arrives while the controller waits can rewrite the pending request, or can complete it. The data array, tag compare and bus arbiter are outside the block. They are represented by `snp_hit`, `bus_grant` and `bus_shared_in`.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After a synchronous reset the line is Invalid, `cpu_ready` is 1 and every other output is 0.
- R2: A load in Invalid raises `bus_req` with command BusRd (code 0). On the grant cycle the line becomes Shared if `bus_shared_in` is 1, and Exclusive otherwise.
- R3: While waiting, `bus_req` and `bus_cmd` stay unchanged until `bus_grant`. The cycle after the grant, `bus_req` is 0, `cpu_done` pulses and `cpu_ready` is 1.
- R4: A store in Exclusive moves the line to Modified with no bus request. A store in Shared requests BusUpgr (code 2). A store in Invalid requests BusRdX (code 1).
- R5: In Modified, a snooped BusRd drives shared, dirty and flush, and the line moves to Shared. A snooped BusRdX drives the same three outputs, and the line moves to Invalid.
- R6: In Exclusive or Shared, a snooped BusRdX or BusUpgr invalidates the line. A snooped BusRd moves Exclusive to Shared. In both cases only shared is answered.
- R7: A snooped BusWB (code 3) has no effect on the state and gives no response.
- R8: Evicting a Modified line requests BusWB and ends in Invalid on the grant. Evicting a clean line goes to Invalid at once, with no bus request. A BusRd or BusRdX that hits while a writeback waits flushes the line and completes the eviction.
- R9: A BusRdX or BusUpgr that hits while an upgrade waits changes the pending command to BusRdX.
- R10: A load that hits in Modified, Exclusive or Shared, and a store that hits in Modified, complete with `cpu_done` in the next cycle and no bus request.
- R11: `snp_shared` is 1 only for a hitting snoop (`snp_hit`=1) on a valid line. `snp_dirty` is 1 only when that line holds Modified data.
- R12: Only one request is outstanding at a time. `cpu_ready` is 0 while a request waits, and `cpu_valid` is ignored while `cpu_ready` is 0.
- R13: When a snoop and a processor request arrive in the same cycle, the snoop is applied first. The request is then judged against the resulting state.

Processor operations on `cpu_op`: 0 load, 1 store, 2 evict, 3 no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 load, 1 store, 2 evict, 3 none |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_done | output | 1 | One-cycle pulse when a request completes |
| bus_req | output | 1 | Bus request pending |
| bus_cmd | output | 2 | Pending command: 0 BusRd, 1 BusRdX, 2 BusUpgr, 3 BusWB |
| bus_grant | input | 1 | The pending request has won the bus |
| bus_shared_in | input | 1 | Another cache holds the line, valid with the grant |
| snp_valid | input | 1 | A bus transaction of another agent is observed |
| snp_cmd | input | 2 | Observed command, same code as `bus_cmd` |
| snp_hit | input | 1 | The observed address matches this line |
| snp_shared | output | 1 | Snoop response: valid copy held |
| snp_dirty | output | 1 | Snoop response: modified copy held |
| snp_flush | output | 1 | Line data must be supplied to the bus |

## Verification
A snoop and a processor request can fall in the same cycle. So can a snoop and the cycle in which a pending request is waiting for its grant. The bench drives a load together with a BusRd while the line is Modified, and a store together with a BusRdX while the line is Shared. The expected responses come from applying the snoop first. It also drives a BusRdX against a waiting upgrade, and a BusRd against a waiting writeback. It then checks that the pending command becomes BusRdX, and that the eviction completes with a flush.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  localparam int OP_W  = 2;
  localparam int CMD_W = 2;
  localparam int ST_W  = 3;

  typedef enum logic [ST_W-1:0] {
    ST_I, ST_S, ST_E, ST_M, ST_IS_W, ST_IM_W, ST_SM_W, ST_MI_W
  } line_st_t;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_EVICT = 2'd2, OP_NONE = 2'd3
  } cpu_op_t;

  typedef enum logic [CMD_W-1:0] {
    CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_UPG = 2'd2, CMD_WB = 2'd3
  } bus_cmd_t;

  typedef struct packed {
    logic shared;
    logic dirty;
    logic flush;
  } snp_rsp_t;

  function automatic logic st_valid(line_st_t s);
    return (s == ST_S) || (s == ST_E) || (s == ST_M) ||
           (s == ST_SM_W) || (s == ST_MI_W);
  endfunction

  function automatic logic st_dirty(line_st_t s);
    return (s == ST_M) || (s == ST_MI_W);
  endfunction

  function automatic logic st_waiting(line_st_t s);
    return (s == ST_IS_W) || (s == ST_IM_W) || (s == ST_SM_W) || (s == ST_MI_W);
  endfunction
endpackage

// File: rtl/mesi_snoop_resolve.sv
module mesi_snoop_resolve
  import mesi_pkg::*;
(
  input  line_st_t             cur_st,
  input  logic                 snp_valid,
  input  logic [CMD_W-1:0]     snp_cmd,
  input  logic                 snp_hit,
  output line_st_t             post_st,
  output snp_rsp_t             rsp,
  output logic                 wb_cancel
);
  bus_cmd_t cmd;
  logic     act;
  logic     is_rd;

  assign cmd   = bus_cmd_t'(snp_cmd);
  assign act   = snp_valid && snp_hit && (cmd != CMD_WB);
  assign is_rd = (cmd == CMD_RD);

  always_comb begin
    post_st   = cur_st;
    rsp       = '0;
    wb_cancel = 1'b0;
    if (act && st_valid(cur_st)) begin
      rsp.shared = 1'b1;
      rsp.dirty  = st_dirty(cur_st);
      rsp.flush  = st_dirty(cur_st);
      case (cur_st)
        ST_M:    post_st = is_rd ? ST_S : ST_I;
        ST_E:    post_st = is_rd ? ST_S : ST_I;
        ST_S:    post_st = is_rd ? ST_S : ST_I;
        ST_SM_W: post_st = is_rd ? ST_SM_W : ST_IM_W;
        ST_MI_W: begin
          post_st   = ST_I;
          wb_cancel = 1'b1;
        end
        default: post_st = cur_st;
      endcase
    end
  end
endmodule

// File: rtl/mesi_cpu_step.sv
module mesi_cpu_step
  import mesi_pkg::*;
(
  input  line_st_t             post_st,
  input  logic                 wb_cancel,
  input  logic                 accept,
  input  logic [OP_W-1:0]      op,
  input  logic                 grant,
  input  logic                 grant_shared,
  output line_st_t             nxt_st,
  output logic                 done,
  output logic                 req,
  output logic [CMD_W-1:0]     cmd
);
  cpu_op_t o;
  assign o = cpu_op_t'(op);

  always_comb begin
    nxt_st = post_st;
    done   = wb_cancel;
    case (post_st)
      ST_I: if (accept) begin
        case (o)
          OP_LOAD:  nxt_st = ST_IS_W;
          OP_STORE: nxt_st = ST_IM_W;
          default:  done   = 1'b1;
        endcase
      end
      ST_S: if (accept) begin
        case (o)
          OP_STORE: nxt_st = ST_SM_W;
          OP_EVICT: begin nxt_st = ST_I; done = 1'b1; end
          default:  done = 1'b1;
        endcase
      end
      ST_E: if (accept) begin
        case (o)
          OP_STORE: begin nxt_st = ST_M; done = 1'b1; end
          OP_EVICT: begin nxt_st = ST_I; done = 1'b1; end
          default:  done = 1'b1;
        endcase
      end
      ST_M: if (accept) begin
        if (o == OP_EVICT) nxt_st = ST_MI_W;
        else               done   = 1'b1;
      end
      ST_IS_W: if (grant) begin
        nxt_st = grant_shared ? ST_S : ST_E;
        done   = 1'b1;
      end
      ST_IM_W, ST_SM_W: if (grant) begin
        nxt_st = ST_M;
        done   = 1'b1;
      end
      ST_MI_W: if (grant) begin
        nxt_st = ST_I;
        done   = 1'b1;
      end
      default: nxt_st = post_st;
    endcase
  end

  always_comb begin
    req = st_waiting(nxt_st);
    case (nxt_st)
      ST_IM_W: cmd = CMD_RDX;
      ST_SM_W: cmd = CMD_UPG;
      ST_MI_W: cmd = CMD_WB;
      default: cmd = CMD_RD;
    endcase
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_valid,
  input  logic [OP_W-1:0]  cpu_op,
  output logic             cpu_ready,
  output logic             cpu_done,
  output logic             bus_req,
  output logic [CMD_W-1:0] bus_cmd,
  input  logic             bus_grant,
  input  logic             bus_shared_in,
  input  logic             snp_valid,
  input  logic [CMD_W-1:0] snp_cmd,
  input  logic             snp_hit,
  output logic             snp_shared,
  output logic             snp_dirty,
  output logic             snp_flush
);
  line_st_t         st_q, post_st, nxt_st;
  snp_rsp_t         rsp_c, rsp_q;
  logic             wb_cancel;
  logic             ready_q, done_q, req_q, done_c, req_c;
  logic [CMD_W-1:0] cmd_q, cmd_c;

  mesi_snoop_resolve u_snoop (
    .cur_st    (st_q),
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_hit   (snp_hit),
    .post_st   (post_st),
    .rsp       (rsp_c),
    .wb_cancel (wb_cancel)
  );

  mesi_cpu_step u_step (
    .post_st      (post_st),
    .wb_cancel    (wb_cancel),
    .accept       (cpu_valid && ready_q),
    .op           (cpu_op),
    .grant        (bus_grant),
    .grant_shared (bus_shared_in),
    .nxt_st       (nxt_st),
    .done         (done_c),
    .req          (req_c),
    .cmd          (cmd_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_I;
      ready_q <= 1'b1;
      done_q  <= 1'b0;
      req_q   <= 1'b0;
      cmd_q   <= '0;
      rsp_q   <= '0;
    end else begin
      st_q    <= nxt_st;
      ready_q <= !st_waiting(nxt_st);
      done_q  <= done_c;
      req_q   <= req_c;
      cmd_q   <= cmd_c;
      rsp_q   <= rsp_c;
    end
  end

  assign cpu_ready  = ready_q;
  assign cpu_done   = done_q;
  assign bus_req    = req_q;
  assign bus_cmd    = cmd_q;
  assign snp_shared = rsp_q.shared;
  assign snp_dirty  = rsp_q.dirty;
  assign snp_flush  = rsp_q.flush;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk
  import mesi_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cpu_ready,
  input logic             cpu_done,
  input logic             bus_req,
  input logic [CMD_W-1:0] bus_cmd,
  input logic             bus_grant,
  input logic             snp_valid,
  input logic [CMD_W-1:0] snp_cmd,
  input logic             snp_hit,
  input logic             snp_shared,
  input logic             snp_dirty,
  input logic             snp_flush
);
  AST_READY_LOW_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !cpu_ready); // R12
  AST_DIRTY_WITH_SHARED: assert property (@(posedge clk) disable iff (rst)
    snp_dirty |-> snp_shared); // R11
  AST_FLUSH_WITH_DIRTY: assert property (@(posedge clk) disable iff (rst)
    snp_flush |-> snp_dirty); // R5
  AST_WB_SILENT: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_cmd == CMD_WB) |=> !snp_shared); // R7
  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!snp_valid || !snp_hit) |=> (!snp_shared && !snp_flush)); // R11
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_grant && !snp_valid) |=> (bus_req && $stable(bus_cmd))); // R3
  AST_GRANT_DONE: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_grant && !snp_valid) |=> (!bus_req && cpu_done && cpu_ready)); // R3
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_ready  (cpu_ready),
  .cpu_done   (cpu_done),
  .bus_req    (bus_req),
  .bus_cmd    (bus_cmd),
  .bus_grant  (bus_grant),
  .snp_valid  (snp_valid),
  .snp_cmd    (snp_cmd),
  .snp_hit    (snp_hit),
  .snp_shared (snp_shared),
  .snp_dirty  (snp_dirty),
  .snp_flush  (snp_flush)
);

// File: tb/mesi_line_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_line_ctrl_bench;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, EV = 2'd2;
  localparam logic [1:0] RD = 2'd0, RDX = 2'd1, UPG = 2'd2, WB = 2'd3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1;
  logic       cpu_valid = 1'b0, bus_grant = 1'b0, bus_shared_in = 1'b0;
  logic       snp_valid = 1'b0, snp_hit = 1'b0;
  logic [1:0] cpu_op = 2'd3, snp_cmd = 2'd0;
  logic       cpu_ready, cpu_done, bus_req, snp_shared, snp_dirty, snp_flush;
  logic [1:0] bus_cmd;

  mesi_line_ctrl u_mesi_line_ctrl (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .bus_req(bus_req),
    .bus_cmd(bus_cmd), .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_hit(snp_hit),
    .snp_shared(snp_shared), .snp_dirty(snp_dirty), .snp_flush(snp_flush)
  );

  typedef struct {
    int         due;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int    cyc = 0, checks = 0, errors = 0;
  bit    finished = 1'b0;
  wire [7:0] obs = {cpu_ready, cpu_done, bus_req, bus_cmd, snp_shared, snp_dirty, snp_flush};

  // monitor: pops expectations whose cycle has come
  always @(posedge clk) begin
    item_t it;
    #1;
    cyc++;
    while (q.size() > 0 && q[0].due == cyc) begin
      it = q.pop_front();
      checks++;
      if (obs !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b (rdy,done,req,cmd,sh,dty,fl)",
                 it.req, obs, it.exp);
      end
    end
  end

  // driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(input logic v, input logic [1:0] op, input logic g,
                      input logic shi, input logic sv, input logic [1:0] sc,
                      input logic sh, input logic [7:0] e, input string r);
    item_t it;
    @(negedge clk);
    cpu_valid = v; cpu_op = op; bus_grant = g; bus_shared_in = shi;
    snp_valid = sv; snp_cmd = sc; snp_hit = sh;
    it.due = cyc + 1; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(0, LD, 0, 0, 0, RD, 0, 8'b1_0_0_00_000, "R1 reset state");
    step(1, LD, 0, 0, 0, RD, 0, 8'b0_0_1_00_000, "R2 load miss BusRd");
    step(1, ST, 0, 0, 0, RD, 0, 8'b0_0_1_00_000, "R12 request ignored while waiting");
    step(0, LD, 1, 0, 0, RD, 0, 8'b1_1_0_00_000, "R2 grant without sharer");
    step(1, ST, 0, 0, 0, RD, 0, 8'b1_1_0_00_000, "R4 store in E silent");
    step(0, LD, 0, 0, 1, WB, 1, 8'b1_0_0_00_000, "R7 BusWB ignored");
    step(0, LD, 0, 0, 1, RD, 1, 8'b1_0_0_00_111, "R5 BusRd in M flushes");
    step(0, LD, 0, 0, 1, RD, 1, 8'b1_0_0_00_100, "R11 shared only in S");
    step(1, ST, 0, 0, 0, RD, 0, 8'b0_0_1_10_000, "R4 store in S upgrade");
    step(0, LD, 0, 0, 0, RD, 0, 8'b0_0_1_10_000, "R3 upgrade held");
    step(0, LD, 0, 0, 1, RDX, 1, 8'b0_0_1_01_100, "R9 upgrade becomes BusRdX");
    step(0, LD, 1, 0, 0, RD, 0, 8'b1_1_0_00_000, "R3 grant completes");
    step(0, LD, 0, 0, 1, RDX, 0, 8'b1_0_0_00_000, "R11 tag miss ignored");
    step(1, EV, 0, 0, 0, RD, 0, 8'b0_0_1_11_000, "R8 evict M writeback");
    step(0, LD, 1, 0, 0, RD, 0, 8'b1_1_0_00_000, "R8 writeback granted");
    step(0, LD, 0, 0, 1, RD, 1, 8'b1_0_0_00_000, "R11 no response in I");
    step(1, LD, 0, 0, 0, RD, 0, 8'b0_0_1_00_000, "R2 load miss again");
    step(0, LD, 1, 1, 0, RD, 0, 8'b1_1_0_00_000, "R2 grant with sharer");
    step(1, LD, 0, 0, 0, RD, 0, 8'b1_1_0_00_000, "R10 load hit in S");
    step(0, LD, 0, 0, 1, RDX, 1, 8'b1_0_0_00_100, "R6 BusRdX invalidates S");
    step(1, ST, 0, 0, 0, RD, 0, 8'b0_0_1_01_000, "R4 store miss BusRdX");
    step(0, LD, 1, 0, 0, RD, 0, 8'b1_1_0_00_000, "R3 grant to M");
    step(1, LD, 0, 0, 1, RD, 1, 8'b1_1_0_00_111, "R13 load with BusRd same cycle");
    step(1, ST, 0, 0, 1, RDX, 1, 8'b0_0_1_01_100, "R13 store with BusRdX same cycle");
    step(0, LD, 1, 0, 0, RD, 0, 8'b1_1_0_00_000, "R3 grant to M");
    step(1, ST, 0, 0, 0, RD, 0, 8'b1_1_0_00_000, "R10 store hit in M");
    step(0, LD, 0, 0, 1, RDX, 1, 8'b1_0_0_00_111, "R5 BusRdX in M flushes");
    step(1, LD, 0, 0, 0, RD, 0, 8'b0_0_1_00_000, "R5 line invalid after BusRdX");
    step(0, LD, 1, 0, 0, RD, 0, 8'b1_1_0_00_000, "R2 grant to E");
    step(0, LD, 0, 0, 1, RD, 1, 8'b1_0_0_00_100, "R6 BusRd in E not dirty");
    step(1, ST, 0, 0, 0, RD, 0, 8'b0_0_1_10_000, "R6 E demoted to S");
    step(0, LD, 1, 0, 0, RD, 0, 8'b1_1_0_00_000, "R3 upgrade granted");
    step(0, LD, 0, 0, 1, RD, 1, 8'b1_0_0_00_111, "R5 BusRd in M");
    step(1, EV, 0, 0, 0, RD, 0, 8'b1_1_0_00_000, "R8 clean evict no bus");
    step(1, LD, 0, 0, 0, RD, 0, 8'b0_0_1_00_000, "R8 line gone after clean evict");
    step(0, LD, 1, 0, 0, RD, 0, 8'b1_1_0_00_000, "R2 grant to E");
    step(0, LD, 0, 0, 1, UPG, 1, 8'b1_0_0_00_100, "R6 BusUpgr invalidates E");
    step(1, ST, 0, 0, 0, RD, 0, 8'b0_0_1_01_000, "R6 invalid after BusUpgr");
    step(0, LD, 1, 0, 0, RD, 0, 8'b1_1_0_00_000, "R3 grant to M");
    step(1, EV, 0, 0, 0, RD, 0, 8'b0_0_1_11_000, "R8 evict M writeback");
    step(0, LD, 0, 0, 1, RD, 1, 8'b1_1_0_00_111, "R8 snoop completes waiting writeback");
    step(0, LD, 0, 0, 0, RD, 0, 8'b1_0_0_00_000, "R12 idle after completion");
    repeat (3) @(posedge clk);
    #2;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R3 actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule